// File: doc/BRIEF.md
# Wired-AND Serial Clock Synchronizer

This block produces one master's serial clock on a shared open-drain clock line where several masters, each with its own rate, drive the same wire. The line is the wired-AND of every master's output, so it is low whenever any master pulls it low. The block counts a programmable low period while it pulls the line low. It then lets go and counts a programmable high period. That high count starts only once the line has really risen. Any pull-low from another master during the high phase cuts the phase short. The master with the longest low time therefore sets the bus low time, and the master with the shortest high time sets the bus high time.

The line level comes in through a two-stage synchronizer, and edges are found on the synchronized value. One-cycle strobes tell the surrounding data logic when data may change (start of the low phase) and when it may be sampled (start of the high phase, once the line has been seen high). A wait output reports each cycle in which the block has let go of the line but still reads it low. Start and stop conditions and data shifting belong to other logic.

Top module: `clksync_top`

## Requirements
- R1: While `rstN` is low all outputs are 0. Whenever `enable` is sampled low at a clock edge, `pullLow`, both strobes and `waitFlag` are 0 after that edge, and the block stays quiet until `enable` returns.
- R2: On the edge after `enable` is first sampled high, and at the start of every later low phase, `pullLow` goes to 1 and stays at 1 for exactly `lowCount` cycles.
- R3: A `lowCount` or `highCount` of 0 acts as a count of 1.
- R4: After the low phase the line is released, and the high count does not start while the synchronized line reads low. The high phase begins on the edge after a rising edge of the synchronized line has been seen, and that line is `lineIn` delayed by two flops.
- R5: When no other master pulls the line, the high phase lasts `highCount` cycles, and then `pullLow` rises again. With the line following `pullLow` at once, the released stretch is `highCount` + 3 cycles.
- R6: If the synchronized line falls during the high phase, the next edge starts a new low phase of the full programmed length.
- R7: `changeStrobe` is 1 for exactly the first cycle of each low phase. `sampleStrobe` is 1 for exactly the first cycle of each high phase.
- R8: `waitFlag` is 1 in every cycle in which the block is enabled and has released the line, but the synchronized line reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Clock generation enable |
| lowCount | input | 16 | Low period in system clock cycles (0 means 1) |
| highCount | input | 16 | High period in system clock cycles (0 means 1) |
| lineIn | input | 1 | Resolved level of the shared clock line (asynchronous) |
| pullLow | output | 1 | Drive the clock line low when 1 (open-drain enable) |
| changeStrobe | output | 1 | One-cycle pulse: data may change |
| sampleStrobe | output | 1 | One-cycle pulse: data may be sampled |
| waitFlag | output | 1 | Released but line still low (held by another master) |

## Verification
A wrong phase register or a wrong compare on the counter shows up within one cycle as a `pullLow` pulse that is one cycle too long or too short, or as a strobe in the wrong cycle. The bench model predicts each output on every clock, so such a fault is caught on the first clock where the output goes wrong. A wrong synchronizer depth or wrong edge detection moves the high-phase start and the end of `waitFlag` by a cycle, and a free-running high counter shows up as a missing early `pullLow` when a short external pulse arrives. Each fault becomes visible at the ports during the first bus period that uses the affected path.

// File: rtl/clksync_pkg.sv
package clksync_pkg;

  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;

  // control -> datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } cnt_cmd_t;

  // datapath -> control
  typedef struct packed {
    logic lineS;
    logic rise;
    logic fall;
    logic lowDone;
    logic highDone;
    logic cntZero;
  } dp_stat_t;

endpackage

// File: rtl/clksync_dp.sv
module clksync_dp
  import clksync_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  cnt_cmd_t      cmd,
  input  logic [CW-1:0] lowCount,
  input  logic [CW-1:0] highCount,
  input  logic          lineIn,
  output dp_stat_t      stat
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   linePrev;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          lowEff;
  logic [CW-1:0]          highEff;
  logic [CW:0]            cntNext;

  // synchronizer chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b1;
          else       syncQ[0] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[g] <= 1'b1;
          else       syncQ[g] <= syncQ[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linePrev <= 1'b1;
      cnt      <= '0;
    end else begin
      linePrev <= syncQ[SYNC_STAGES-1];
      if (cmd.clr)
        cnt <= '0;
      else if (cmd.inc && (cnt != '1))
        cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    lowEff  = (lowCount  == '0) ? CW'(1) : lowCount;
    highEff = (highCount == '0) ? CW'(1) : highCount;
    cntNext = {1'b0, cnt} + 1'b1;

    stat.lineS    = syncQ[SYNC_STAGES-1];
    stat.rise     = syncQ[SYNC_STAGES-1] & ~linePrev;
    stat.fall     = ~syncQ[SYNC_STAGES-1] & linePrev;
    stat.lowDone  = cntNext >= {1'b0, lowEff};
    stat.highDone = cntNext >= {1'b0, highEff};
    stat.cntZero  = (cnt == '0);
  end

endmodule

// File: rtl/clksync_ctrl.sv
module clksync_ctrl
  import clksync_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  dp_stat_t stat,
  output cnt_cmd_t cmd,
  output logic     pullLow,
  output logic     changeStrobe,
  output logic     sampleStrobe,
  output logic     waitFlag
);

  phase_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd.clr   = 1'b0;
    cmd.inc   = 1'b0;
    unique case (state)
      PH_OFF: begin
        cmd.clr   = 1'b1;
        stateNext = PH_LOW;
      end
      PH_LOW: begin
        cmd.inc = 1'b1;
        if (stat.lowDone) stateNext = PH_WAIT;
      end
      PH_WAIT: begin
        cmd.clr = 1'b1;
        if (stat.rise) stateNext = PH_HIGH;
      end
      PH_HIGH: begin
        if (stat.fall || stat.highDone) begin
          cmd.clr   = 1'b1;
          stateNext = PH_LOW;
        end else begin
          cmd.inc = 1'b1;
        end
      end
      default: stateNext = PH_OFF;
    endcase
    if (!enable) begin
      stateNext = PH_OFF;
      cmd.clr   = 1'b1;
      cmd.inc   = 1'b0;
    end
  end

  always_comb begin
    pullLow      = (state == PH_LOW);
    changeStrobe = (state == PH_LOW)  && stat.cntZero;
    sampleStrobe = (state == PH_HIGH) && stat.cntZero;
    waitFlag     = ((state == PH_WAIT) || (state == PH_HIGH)) && !stat.lineS;
  end

  // R1: a disabled block lets go of the line on the next edge
  a_r1_release_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pullLow);

  // R7: every new pull-low comes with the change strobe
  a_r7_change_on_pull: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullLow) |-> changeStrobe);

  // R6: a falling line during the high phase restarts the low phase
  a_r6_fall_cuts_high: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HIGH && stat.fall && enable) |=> pullLow);

  // R4: no high phase without a seen rising edge
  a_r4_no_high_without_rise: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT && !stat.rise) |=> state != PH_HIGH);

endmodule

// File: rtl/clksync_top.sv
module clksync_top
  import clksync_pkg::*;
#(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [CW-1:0] lowCount,
  input  logic [CW-1:0] highCount,
  input  logic          lineIn,
  output logic          pullLow,
  output logic          changeStrobe,
  output logic          sampleStrobe,
  output logic          waitFlag
);

  cnt_cmd_t cmd;
  dp_stat_t stat;

  clksync_dp #(
    .CW          (CW),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .lowCount  (lowCount),
    .highCount (highCount),
    .lineIn    (lineIn),
    .stat      (stat)
  );

  clksync_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .stat         (stat),
    .cmd          (cmd),
    .pullLow      (pullLow),
    .changeStrobe (changeStrobe),
    .sampleStrobe (sampleStrobe),
    .waitFlag     (waitFlag)
  );

endmodule

// File: tb/clksync_top_tb.sv
module clksync_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] lowCount = 16'd4;
  logic [15:0] highCount = 16'd6;
  logic        extLow = 1'b0;
  logic        lineIn;
  logic        pullLow, changeStrobe, sampleStrobe, waitFlag;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  string curReq = "R1";

  assign lineIn = !(pullLow || extLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  clksync_top dut_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lowCount(lowCount), .highCount(highCount), .lineIn(lineIn),
    .pullLow(pullLow), .changeStrobe(changeStrobe),
    .sampleStrobe(sampleStrobe), .waitFlag(waitFlag)
  );

  // behavioural reference: phase 0 off, 1 low, 2 released-waiting, 3 high
  int mPhase = 0, mCnt = 0;
  bit mS1 = 1, mS2 = 1, mPrev = 1;
  bit ePull = 0, eChg = 0, eSmp = 0, eWait = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mS1 = 1; mS2 = 1; mPrev = 1;
    end else begin
      int le, he, np, nc;
      bit up, down;
      le = (lowCount == 0) ? 1 : int'(lowCount);
      he = (highCount == 0) ? 1 : int'(highCount);
      up = mS2 && !mPrev;
      down = !mS2 && mPrev;
      np = mPhase; nc = mCnt;
      if (!enable) begin
        np = 0; nc = 0;
      end else if (mPhase == 0) begin
        np = 1; nc = 0;
      end else if (mPhase == 1) begin
        nc = mCnt + 1;
        if (mCnt + 1 >= le) np = 2;
      end else if (mPhase == 2) begin
        nc = 0;
        if (up) np = 3;
      end else begin
        if (down || (mCnt + 1 >= he)) begin np = 1; nc = 0; end
        else nc = mCnt + 1;
      end
      mPhase = np; mCnt = nc;
      mPrev = mS2; mS2 = mS1; mS1 = lineIn;
    end
    ePull = (mPhase == 1);
    eChg  = (mPhase == 1) && (mCnt == 0);
    eSmp  = (mPhase == 3) && (mCnt == 0);
    eWait = (mPhase >= 2) && !mS2;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
    end
  endtask

  task automatic checkInt(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // run-length monitors of pull and release stretches
  int pullRun = 0, lastPullRun = 0, relRun = 0, lastRelRun = 0;

  always @(negedge clk) begin
    check(curReq, "pullLow", pullLow, ePull);
    check("R7", "changeStrobe", changeStrobe, eChg);
    check("R7", "sampleStrobe", sampleStrobe, eSmp);
    check("R8", "waitFlag", waitFlag, eWait);
    if (pullLow) begin
      pullRun++;
      if (relRun != 0) lastRelRun = relRun;
      relRun = 0;
    end else begin
      if (pullRun != 0) lastPullRun = pullRun;
      pullRun = 0;
      if (enable) relRun++;
    end
  end

  // other master on the line: 0 none, 1 free-running slow clock, 2 short pulses
  int extMode = 0, extCnt = 0;
  always @(negedge clk) begin
    extCnt++;
    case (extMode)
      1: extLow = (extCnt % 40) < 15;
      2: extLow = (extCnt % 13) < 2;
      default: extLow = 1'b0;
    endcase
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    curReq = "R1";
    cycles(4);
    check("R1", "pullLow in reset", pullLow, 1'b0);
    check("R1", "waitFlag in reset", waitFlag, 1'b0);
    rstN = 1'b1;
    cycles(3);
    check("R1", "pullLow while disabled", pullLow, 1'b0);

    // R2 and R5: alone on the bus, low 4, high 6
    curReq = "R2";
    enable = 1'b1;
    cycles(1);
    check("R2", "pullLow after enable", pullLow, 1'b1);
    cycles(70);
    checkInt("R2", "low stretch", lastPullRun, 4);
    checkInt("R5", "released stretch", lastRelRun, 6 + 3);

    // R3: zero counts act as one
    curReq = "R3";
    lowCount = 16'd0; highCount = 16'd0;
    cycles(40);
    checkInt("R3", "low stretch for zero", lastPullRun, 1);
    checkInt("R3", "released stretch for zero", lastRelRun, 1 + 3);

    // R4: another master holds the line low longer than this block
    curReq = "R4";
    lowCount = 16'd3; highCount = 16'd30;
    extMode = 1;
    cycles(200);

    // R6: short external pulses cut a long high phase
    curReq = "R6";
    lowCount = 16'd5; highCount = 16'd40;
    extMode = 2;
    cycles(200);
    checkInt("R6", "low stretch keeps full length", lastPullRun, 5);

    // R1: disable in mid-run, then restart
    curReq = "R1";
    extMode = 0;
    enable = 1'b0;
    cycles(1);
    check("R1", "pullLow after disable", pullLow, 1'b0);
    cycles(10);
    check("R1", "still released", pullLow, 1'b0);
    curReq = "R2";
    lowCount = 16'd7; highCount = 16'd2;
    enable = 1'b1;
    cycles(60);
    checkInt("R2", "low stretch after restart", lastPullRun, 7);
    checkInt("R5", "released stretch after restart", lastRelRun, 2 + 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule